// File: doc/BRIEF.md
# AES-128 Bidirectional Key Schedule Stepper

This block holds one 128-bit AES round key together with its round number (0 to 10) and moves through the AES-128 key schedule one round per clock, in either direction. A forward step turns round key i into round key i+1. An inverse step turns round key i into round key i-1. An encryption datapath can therefore start from the cipher key and walk up the schedule. A decryption datapath can start from the last round key and walk down, so no table of expanded keys needs to be stored.

A load pulse captures a key and its round number, and load wins over a step in the same cycle. Every step derives a 32-bit word by rotating one key word left by a byte and passing the four bytes through the AES S-box. The block then XORs in a round constant taken from the round number. The S-boxes are computed as a GF(2^8) inversion followed by the affine map, so there is no stored table.

Top module: `aes128_key_stepper`

## Requirements
- R1: After reset, key_o is all zeros and round_o is 0.
- R2: A cycle with load_i high stores key_i and round_i, and they appear on key_o and round_o after that clock edge. A round_i above 10 is stored as 10.
- R3: When load_i and step_i are both high, the load takes effect and the step is dropped.
- R4: A forward step (step_i high, dir_i = 0) with round_o below 10 replaces the key with the next round key and adds 1 to round_o. The key words are w0 = key[127:96] through w3 = key[31:0], and byte 0 of each word is its top byte. The new words are n0 = w0 ^ S(rotl8(w3)) ^ rc, n1 = w1 ^ n0, n2 = w2 ^ n1 and n3 = w3 ^ n2.
- R5: The constant rc is {RC, 24'h0}, where RC is the byte for the target round t = round_o+1 of the forward step. For t = 1 to 10, RC is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (hex).
- R6: An inverse step (step_i high, dir_i = 1) with round_o above 0 replaces the key with the previous round key and subtracts 1 from round_o. The inverse uses the constant of decryption round k = 11 - round_o, which is the constant of encryption round round_o. Applying a forward step and then an inverse step returns the original key.
- R7: A forward step at round 10, or an inverse step at round 0, changes neither key_o nor round_o.
- R8: In a cycle with neither load_i nor step_i high, key_o and round_o hold their values.
- R9: Ten forward steps from cipher key 000102030405060708090a0b0c0d0e0f give 13111d7fe3944a17f307a78b4d2b30c5. Ten inverse steps from there return the cipher key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture key_i and round_i |
| step_i | input | 1 | Advance the schedule by one round |
| dir_i | input | 1 | Step direction: 0 forward, 1 inverse |
| key_i | input | 128 | Key to load |
| round_i | input | 4 | Round number to load |
| key_o | output | 128 | Current round key |
| round_o | output | 4 | Current round number |

## Verification
On every cycle, the assertions check the bookkeeping of the round number. It stays in range, load saturates it, forward steps add one and inverse steps subtract one. They also check that the key holds at a limit and in idle cycles, and that a round constant exists for every legal round. Whether the key words are right can only be shown by the bench scenarios. The bench walks a published schedule up and down, and runs a round trip on a second key to reach its known last round key. It also loads from the middle of the schedule and checks that load wins over a step.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 4 * BYTE_W;
   localparam int KEY_W  = 4 * WORD_W;

   function automatic logic [7:0] gf_xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_xtime(sh);
      end
      return acc;
   endfunction

   // x^254 = x^-1 in GF(2^8); zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] x);
      logic [7:0] sq;
      logic [7:0] prod;
      sq   = x;
      prod = 8'h01;
      for (int k = 1; k < 8; k++) begin
         sq   = gf_mul(sq, sq);
         prod = gf_mul(prod, sq);
      end
      return prod;
   endfunction

   function automatic logic [7:0] rotl8b(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
      logic [7:0] b;
      b = gf_inv(x);
      return b ^ rotl8b(b, 1) ^ rotl8b(b, 2) ^ rotl8b(b, 3) ^ rotl8b(b, 4) ^ 8'h63;
   endfunction
endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
   import aes_ks_pkg::*;
#(
   parameter int STYLE = 0   // 0: inversion then affine, 1: constant-folded case table
) (
   input  logic [7:0] in_b,
   output logic [7:0] out_b
);
   if (STYLE == 0) begin : g_math
      assign out_b = sbox_fwd(in_b);
   end else if (STYLE == 1) begin : g_fold
      always_comb begin
         out_b = 8'h00;
         for (int v = 0; v < 256; v++) begin
            if (in_b == 8'(v)) out_b = sbox_fwd(8'(v));
         end
      end
   end else begin : g_bad_style
      $error("aes_ks_sbox: STYLE must be 0 or 1");
   end
endmodule

// File: rtl/aes_ks_subrot.sv
module aes_ks_subrot
   import aes_ks_pkg::*;
#(
   parameter int SBOX_STYLE = 0
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int NBYTES = WORD_W / BYTE_W;
   logic [WORD_W-1:0] rot;

   // rotate left by one byte: top byte moves to the bottom
   assign rot = {word_i[WORD_W-BYTE_W-1:0], word_i[WORD_W-1 -: BYTE_W]};

   for (genvar g = 0; g < NBYTES; g++) begin : g_sb
      aes_ks_sbox #(.STYLE(SBOX_STYLE)) u_sb (
         .in_b  (rot[g*BYTE_W +: BYTE_W]),
         .out_b (word_o[g*BYTE_W +: BYTE_W])
      );
   end
endmodule

// File: rtl/aes_ks_rcon.sv
module aes_ks_rcon
   import aes_ks_pkg::*;
#(
   parameter int RND_W      = 4,
   parameter int NUM_ROUNDS = 10
) (
   input  logic [RND_W-1:0]  idx_i,      // target encryption round, or decryption round when inv_i
   input  logic              inv_i,
   output logic [WORD_W-1:0] rcon_o
);
   logic [RND_W-1:0] enc_idx;
   logic [7:0]       rc;
   logic             idx_ok;

   // decryption round k uses the constant of encryption round NUM_ROUNDS+1-k
   assign enc_idx = inv_i ? (RND_W'(NUM_ROUNDS + 1) - idx_i) : idx_i;
   assign idx_ok  = (enc_idx != '0) && (enc_idx <= RND_W'(NUM_ROUNDS));

   always_comb begin
      rc = 8'h01;
      for (int i = 2; i <= NUM_ROUNDS; i++) begin
         if (int'(enc_idx) >= i) rc = gf_xtime(rc);
      end
      if (!idx_ok) rc = 8'h00;
   end

   assign rcon_o = {rc, {(WORD_W-8){1'b0}}};

   always_comb begin
      if (idx_ok && !$isunknown(enc_idx))
         AST_RCON_PRESENT: assert (rc != 8'h00); // R5
   end
endmodule

// File: rtl/aes_ks_round.sv
module aes_ks_round
   import aes_ks_pkg::*;
#(
   parameter int SBOX_STYLE = 0
) (
   input  logic [KEY_W-1:0]  key_i,
   input  logic [WORD_W-1:0] rcon_i,
   input  logic              inv_i,
   output logic [KEY_W-1:0]  key_o
);
   logic [WORD_W-1:0] w [4];
   logic [WORD_W-1:0] f [4];
   logic [WORD_W-1:0] b [4];
   logic [WORD_W-1:0] sr_in, sr_out;

   for (genvar g = 0; g < 4; g++) begin : g_split
      assign w[g] = key_i[KEY_W-1-g*WORD_W -: WORD_W];
   end

   // inverse: the old last word is the XOR of the two newest words
   assign b[3]  = w[3] ^ w[2];
   assign b[2]  = w[2] ^ w[1];
   assign b[1]  = w[1] ^ w[0];

   // one shared word function, fed by the direction
   assign sr_in = inv_i ? b[3] : w[3];

   aes_ks_subrot #(.SBOX_STYLE(SBOX_STYLE)) u_subrot (
      .word_i (sr_in),
      .word_o (sr_out)
   );

   assign b[0] = w[0] ^ sr_out ^ rcon_i;
   assign f[0] = w[0] ^ sr_out ^ rcon_i;
   for (genvar g = 1; g < 4; g++) begin : g_chain
      assign f[g] = w[g] ^ f[g-1];
   end

   assign key_o = inv_i ? {b[0], b[1], b[2], b[3]} : {f[0], f[1], f[2], f[3]};
endmodule

// File: rtl/aes128_key_stepper.sv
module aes128_key_stepper
   import aes_ks_pkg::*;
#(
   parameter int RND_W      = 4,
   parameter int NUM_ROUNDS = 10,
   parameter int SBOX_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             dir_i,
   input  logic [127:0]     key_i,
   input  logic [RND_W-1:0] round_i,
   output logic [127:0]     key_o,
   output logic [RND_W-1:0] round_o
);
   localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS);

   if (NUM_ROUNDS >= (1 << RND_W)) begin : g_bad_rw
      $error("aes128_key_stepper: RND_W too narrow for NUM_ROUNDS");
   end
   if (KEY_W != 128) begin : g_bad_kw
      $error("aes128_key_stepper: key width must be 128");
   end

   logic [KEY_W-1:0]  key_q, key_nx;
   logic [RND_W-1:0]  rnd_q;
   logic [RND_W-1:0]  rc_idx;
   logic [WORD_W-1:0] rcon;
   logic              can_fwd, can_inv, do_step;

   assign can_fwd = (rnd_q != RND_LAST);
   assign can_inv = (rnd_q != '0);
   assign do_step = step_i && !load_i && (dir_i ? can_inv : can_fwd);

   // forward: target round; inverse: decryption round number
   assign rc_idx = dir_i ? (RND_W'(NUM_ROUNDS + 1) - rnd_q) : (rnd_q + 1'b1);

   aes_ks_rcon #(.RND_W(RND_W), .NUM_ROUNDS(NUM_ROUNDS)) u_rcon (
      .idx_i  (rc_idx),
      .inv_i  (dir_i),
      .rcon_o (rcon)
   );

   aes_ks_round #(.SBOX_STYLE(SBOX_STYLE)) u_round (
      .key_i  (key_q),
      .rcon_i (rcon),
      .inv_i  (dir_i),
      .key_o  (key_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         rnd_q <= '0;
      end else if (load_i) begin
         key_q <= key_i;
         rnd_q <= (round_i > RND_LAST) ? RND_LAST : round_i;
      end else if (do_step) begin
         key_q <= key_nx;
         rnd_q <= dir_i ? (rnd_q - 1'b1) : (rnd_q + 1'b1);
      end
   end

   assign key_o   = key_q;
   assign round_o = rnd_q;

   AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      round_o <= RND_LAST); // R2
   AST_LOAD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && round_i > RND_LAST) |=> (round_o == RND_LAST)); // R2
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && step_i) |=> (key_o == $past(key_i))); // R3
   AST_FWD_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !dir_i && round_o < RND_LAST) |=> (round_o == $past(round_o) + 1'b1)); // R4
   AST_INV_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && dir_i && round_o != '0) |=> (round_o == $past(round_o) - 1'b1)); // R6
   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && ((!dir_i && round_o == RND_LAST) || (dir_i && round_o == '0)))
      |=> ($stable(key_o) && $stable(round_o))); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> ($stable(key_o) && $stable(round_o))); // R8
endmodule

// File: tb/tb_aes128_key_stepper.sv
module tb_aes128_key_stepper;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0, step_i = 1'b0, dir_i = 1'b0;
   logic [127:0] key_i = '0;
   logic [3:0]   round_i = '0;
   logic [127:0] key_o;
   logic [3:0]   round_o;
   int           n_chk = 0, n_bad = 0;
   int           cyc = 0;

   always #4 clk = ~clk;   // 125 MHz

   aes128_key_stepper dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i), .dir_i(dir_i),
      .key_i(key_i), .round_i(round_i), .key_o(key_o), .round_o(round_o)
   );

   // published schedule of cipher key 2b7e1516...
   localparam logic [127:0] SCHED [0:10] = '{
      128'h2b7e151628aed2a6abf7158809cf4f3c,
      128'ha0fafe1788542cb123a339392a6c7605,
      128'hf2c295f27a96b9435935807a7359f67f,
      128'h3d80477d4716fe3e1e237e446d7a883b,
      128'hef44a541a8525b7fb671253bdb0bad00,
      128'hd4d1c6f87c839d87caf2b8bc11f915bc,
      128'h6d88a37a110b3efddbf98641ca0093fd,
      128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
      128'head27321b58dbad2312bf5607f8d292f,
      128'hac7766f319fadc2128d12941575c006e,
      128'hd014f9a8c9ee2589e13f0cc8b6630ca6
   };
   localparam logic [127:0] KEY_B  = 128'h000102030405060708090a0b0c0d0e0f;
   localparam logic [127:0] KEY_B10 = 128'h13111d7fe3944a17f307a78b4d2b30c5;

   task automatic chk(input string req, input logic [127:0] k_exp, input logic [3:0] r_exp);
      n_chk++;
      if (key_o !== k_exp || round_o !== r_exp) begin
         n_bad++;
         $display("FAIL %s: key=%h round=%0d expected key=%h round=%0d", req, key_o, round_o, k_exp, r_exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, release and sample at the next falling edge
   task automatic cyc_op(input logic ld, input logic st, input logic dr,
                         input logic [127:0] k, input logic [3:0] r);
      @(negedge clk);
      load_i = ld; step_i = st; dir_i = dr; key_i = k; round_i = r;
      @(negedge clk);
      load_i = 1'b0; step_i = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 5000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R1 reset state", '0, 4'd0);
      rst_n = 1'b1;

      // table walk: up the schedule, then back down
      cyc_op(1, 0, 0, SCHED[0], 4'd0);
      chk("R2 load", SCHED[0], 4'd0);
      for (int i = 1; i <= 10; i++) begin
         cyc_op(0, 1, 0, '0, '0);
         chk("R4/R5 forward step", SCHED[i], 4'(i));
      end
      cyc_op(0, 1, 0, '0, '0);
      chk("R7 forward at round 10 ignored", SCHED[10], 4'd10);
      for (int i = 9; i >= 0; i--) begin
         cyc_op(0, 1, 1, '0, '0);
         chk("R6 inverse step", SCHED[i], 4'(i));
      end
      cyc_op(0, 1, 1, '0, '0);
      chk("R7 inverse at round 0 ignored", SCHED[0], 4'd0);

      // mid-schedule load, both directions
      cyc_op(1, 0, 0, SCHED[5], 4'd5);
      cyc_op(0, 1, 0, '0, '0);
      chk("R4 forward from loaded round 5", SCHED[6], 4'd6);
      cyc_op(0, 0, 0, '0, '0);
      cyc_op(0, 0, 1, '0, '0);
      chk("R8 idle holds", SCHED[6], 4'd6);
      cyc_op(1, 0, 0, SCHED[5], 4'd5);
      cyc_op(0, 1, 1, '0, '0);
      chk("R6 inverse from loaded round 5", SCHED[4], 4'd4);

      // load beats step
      cyc_op(1, 1, 0, SCHED[2], 4'd2);
      chk("R3 load wins over step", SCHED[2], 4'd2);
      cyc_op(1, 1, 1, SCHED[9], 4'd9);
      chk("R3 load wins over inverse step", SCHED[9], 4'd9);

      // round index saturation
      cyc_op(1, 0, 0, SCHED[10], 4'd15);
      chk("R2 round saturates at 10", SCHED[10], 4'd10);
      cyc_op(0, 1, 0, '0, '0);
      chk("R7 saturated round blocks forward", SCHED[10], 4'd10);

      // second key: round trip and last round key
      cyc_op(1, 0, 0, KEY_B, 4'd0);
      for (int i = 0; i < 10; i++) cyc_op(0, 1, 0, '0, '0);
      chk("R9 last round key of second key", KEY_B10, 4'd10);
      for (int i = 0; i < 10; i++) cyc_op(0, 1, 1, '0, '0);
      chk("R9 round trip back to second key", KEY_B, 4'd0);

      // asynchronous reset clears state
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 reset clears loaded state", '0, 4'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule